// File: doc/BRIEF.md
# Four-Port PoE Power Sequencer

This block sequences the ports of a four-port Power over Ethernet power sourcing controller. Each port walks through idle, detection, classification, an optional wait for the host and the powered state. Analog front ends report their results as flags: a detection result code, a class result code, an overcurrent fault, and an oscillator-health level used for AC disconnect sensing. The block drives the gate enable and the power-good flag, publishes the latest detection and class codes, and raises one-cycle event pulses.

A host controls the block through a simple byte-wide register write port. Each port has its own operating mode. In manual mode the port runs one detection cycle per host request. In semiauto mode it detects and classifies by itself, then waits for a host power-on command. In auto mode it applies power after a good classification with no host involvement. A global reset bit and the reset pin both return every port and register to its default state.

Top module: `poe_port_seq`

## Requirements
- R1: During and after reset, all gate enables, power-good flags, status codes and event pulses are 0 and the oscillator-fail flag is 1. Every mode bit takes the level of `auto_pin_i`, sampled at reset.
- R2: Register 12h holds the port modes, port n in bits [2n+1:2n]: 00 is manual, 01 is semiauto, 11 is auto and 10 acts as manual. A port in semiauto or auto that sits idle starts detection one cycle after the mode takes effect.
- R3: A manual port stays idle, with `det_req_o` low, until a write to 18h with bit n set. It then runs one detection cycle.
- R4: While a port is detecting, a `det_done_i` pulse latches the 3-bit code (0 unknown, 1 short, 2 low, 3 good, 4 high, 5 open) into `det_status_o`. Code 3 moves the port to classification. Any other code returns it to idle, and in manual mode that also pulses `ev_cls_done_o`.
- R5: While a port is classifying, a `cls_done_i` pulse latches the code (0 unknown, 1 to 5 for class 0 to 4, 6 overcurrent) into `cls_status_o`. Codes 1 to 5 pulse `ev_cls_done_o` for one cycle. Code 6 pulses `ev_fault_o` and returns the port to idle unpowered.
- R6: After a good class in semiauto or manual mode, the port waits with the gate off until a write to 19h with bit n set. The gate turns on in the following cycle.
- R7: In auto mode the gate turns on in the cycle after a good class result, with no host write.
- R8: A power-on write reaches a port only while it waits after classification. In any other state it has no effect.
- R9: `pgood_o` rises exactly PGOOD_CYC cycles after `gate_en_o` rises and stays high while the port is powered.
- R10: `fault_i` on a powered port turns its gate off in the next cycle and pulses `ev_fault_o`. An auto or semiauto port then re-enters detection one cycle later.
- R11: A write to 19h with bit n+4 set returns port n to idle from any state, with the gate off.
- R12: The oscillator-fail flag is set by any reset and in every cycle in which `osc_ok_i` is low. A write to 1Ah with bit 0 set clears it. While the flag is set, a powered port with AC sensing on (13h bit n+4) and DC sensing off (13h bit n) is turned off and pulses `ev_disc_o`.
- R13: A write to 1Ah with bit 7 set restores every R1 default in the next cycle, including modes taken from `auto_pin_i`.
- R14: Ports are independent: a command or input for one port leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_pin_i | input | 1 | Default level for all mode bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| osc_ok_i | input | 1 | Disconnect oscillator healthy |
| det_done_i | input | 4 | Detection result valid, per port |
| det_code_i | input | 12 | Detection result codes, 3 bits per port |
| cls_done_i | input | 4 | Class result valid, per port |
| cls_code_i | input | 12 | Class result codes, 3 bits per port |
| fault_i | input | 4 | Overcurrent fault, per port |
| det_req_o | output | 4 | Detection in progress, per port |
| cls_req_o | output | 4 | Classification in progress, per port |
| gate_en_o | output | 4 | Power switch enable, per port |
| pgood_o | output | 4 | Power good, per port |
| det_status_o | output | 12 | Latest detection codes |
| cls_status_o | output | 12 | Latest class codes |
| ev_cls_done_o | output | 4 | Class-complete event pulse |
| ev_fault_o | output | 4 | Fault event pulse |
| ev_disc_o | output | 4 | Oscillator disconnect event pulse |
| osc_fail_o | output | 1 | Oscillator-fail flag |

## Verification
The hardest case to reach is the oscillator disconnect of a powered port. It needs a port that is already powered, the right AC and DC sensing combination, and the fail flag set either by reset or by a drop of `osc_ok_i` after the flag was cleared. The stimulus powers a port in auto mode while the reset-time flag is still set, then enables AC sensing alone and looks for the turn-off. It then shows that enabling DC sensing blocks the turn-off. Finally it clears the flag, repowers the port and drops the oscillator, checking that the flag and the turn-off follow one cycle apart.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DETECT = 3'd1,
        ST_CLASS  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_ON     = 3'd4
    } port_st_e;

    localparam logic [1:0] MD_MANUAL = 2'b00;
    localparam logic [1:0] MD_SEMI   = 2'b01;
    localparam logic [1:0] MD_AUTO   = 2'b11;

    localparam logic [2:0] DET_UNKNOWN = 3'd0;
    localparam logic [2:0] DET_GOOD    = 3'd3;
    localparam logic [2:0] CLS_UNKNOWN = 3'd0;
    localparam logic [2:0] CLS_OVC     = 3'd6;

    localparam logic [7:0] ADR_MODE    = 8'h12;
    localparam logic [7:0] ADR_DISC    = 8'h13;
    localparam logic [7:0] ADR_RESTART = 8'h18;
    localparam logic [7:0] ADR_POWER   = 8'h19;
    localparam logic [7:0] ADR_GLOBAL  = 8'h1A;

endpackage

// File: rtl/poe_seq_regs.sv
module poe_seq_regs
    import poe_seq_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_pin_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic                   osc_ok_i,
    output logic [2*N_PORTS-1:0]   mode_o,
    output logic [N_PORTS-1:0]     dc_en_o,
    output logic [N_PORTS-1:0]     ac_en_o,
    output logic                   osc_fail_o,
    output logic [N_PORTS-1:0]     restart_o,
    output logic [N_PORTS-1:0]     pon_o,
    output logic [N_PORTS-1:0]     poff_o,
    output logic                   soft_rst_o
);

    localparam int MODE_W = 2 * N_PORTS;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [N_PORTS-1:0] dc_en;
        logic [N_PORTS-1:0] ac_en;
        logic               osc_fail;
    } regs_t;

    regs_t r_d, r_q, dflt;
    logic  hit_mode, hit_disc, hit_rst, hit_pwr, hit_glb;

    always_comb begin
        dflt.mode     = {MODE_W{auto_pin_i}};
        dflt.dc_en    = '0;
        dflt.ac_en    = '0;
        dflt.osc_fail = 1'b1;

        hit_mode = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MODE));
        hit_disc = wr_en_i && (wr_addr_i == ADDR_W'(ADR_DISC));
        hit_rst  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RESTART));
        hit_pwr  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_POWER));
        hit_glb  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_GLOBAL));

        soft_rst_o = hit_glb && wr_data_i[DATA_W-1];
        restart_o  = hit_rst ? wr_data_i[N_PORTS-1:0] : '0;
        pon_o      = hit_pwr ? wr_data_i[N_PORTS-1:0] : '0;
        poff_o     = hit_pwr ? wr_data_i[2*N_PORTS-1:N_PORTS] : '0;

        r_d = r_q;
        if (hit_mode) r_d.mode = wr_data_i[MODE_W-1:0];
        if (hit_disc) begin
            r_d.dc_en = wr_data_i[N_PORTS-1:0];
            r_d.ac_en = wr_data_i[2*N_PORTS-1:N_PORTS];
        end
        if (hit_glb && wr_data_i[0]) r_d.osc_fail = 1'b0;
        if (!osc_ok_i)               r_d.osc_fail = 1'b1;
        if (soft_rst_o)              r_d = dflt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= dflt;
        else        r_q <= r_d;
    end

    assign mode_o     = r_q.mode;
    assign dc_en_o    = r_q.dc_en;
    assign ac_en_o    = r_q.ac_en;
    assign osc_fail_o = r_q.osc_fail;

    AST_SOFT_RST_SETS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> osc_fail_o); // R13
    AST_OSC_LOSS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ok_i |=> osc_fail_o); // R12

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
    import poe_seq_pkg::*;
#(
    parameter int PGOOD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst_i,
    input  logic [1:0] mode_i,
    input  logic       restart_i,
    input  logic       pon_i,
    input  logic       poff_i,
    input  logic       osc_kill_i,
    input  logic       det_done_i,
    input  logic [2:0] det_code_i,
    input  logic       cls_done_i,
    input  logic [2:0] cls_code_i,
    input  logic       fault_i,
    output logic       det_req_o,
    output logic       cls_req_o,
    output logic       gate_en_o,
    output logic       pgood_o,
    output logic [2:0] det_status_o,
    output logic [2:0] cls_status_o,
    output logic       ev_cls_o,
    output logic       ev_fault_o,
    output logic       ev_disc_o
);

    localparam int CNT_W = $clog2(PGOOD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PGOOD_CYC);

    typedef struct packed {
        port_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       det_st;
        logic [2:0]       cls_st;
        logic             ev_cls;
        logic             ev_fault;
        logic             ev_disc;
    } port_t;

    localparam port_t PORT_RST = '{
        st: ST_IDLE, cnt: '0, det_st: DET_UNKNOWN, cls_st: CLS_UNKNOWN,
        ev_cls: 1'b0, ev_fault: 1'b0, ev_disc: 1'b0
    };

    port_t p_d, p_q;
    logic  is_manual, is_auto;

    always_comb begin
        is_manual = (mode_i != MD_SEMI) && (mode_i != MD_AUTO);
        is_auto   = (mode_i == MD_AUTO);

        p_d          = p_q;
        p_d.ev_cls   = 1'b0;
        p_d.ev_fault = 1'b0;
        p_d.ev_disc  = 1'b0;

        unique case (p_q.st)
            ST_IDLE: begin
                if (!is_manual || restart_i) p_d.st = ST_DETECT;
            end
            ST_DETECT: begin
                if (det_done_i) begin
                    p_d.det_st = det_code_i;
                    if (det_code_i == DET_GOOD) begin
                        p_d.st = ST_CLASS;
                    end else begin
                        p_d.st = ST_IDLE;
                        if (is_manual) p_d.ev_cls = 1'b1;
                    end
                end
            end
            ST_CLASS: begin
                if (cls_done_i) begin
                    p_d.cls_st = cls_code_i;
                    if (cls_code_i == CLS_OVC) begin
                        p_d.st       = ST_IDLE;
                        p_d.ev_fault = 1'b1;
                    end else begin
                        p_d.ev_cls = 1'b1;
                        p_d.cnt    = '0;
                        p_d.st     = is_auto ? ST_ON : ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (pon_i) begin
                    p_d.st  = ST_ON;
                    p_d.cnt = '0;
                end
            end
            ST_ON: begin
                if (osc_kill_i) begin
                    p_d.st      = ST_IDLE;
                    p_d.ev_disc = 1'b1;
                end else if (fault_i) begin
                    p_d.st       = ST_IDLE;
                    p_d.ev_fault = 1'b1;
                end else if (p_q.cnt < CNT_MAX) begin
                    p_d.cnt = p_q.cnt + 1'b1;
                end
            end
            default: p_d.st = ST_IDLE;
        endcase

        if (poff_i)     p_d.st = ST_IDLE;
        if (soft_rst_i) p_d    = PORT_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= PORT_RST;
        else        p_q <= p_d;
    end

    assign det_req_o    = (p_q.st == ST_DETECT);
    assign cls_req_o    = (p_q.st == ST_CLASS);
    assign gate_en_o    = (p_q.st == ST_ON);
    assign pgood_o      = (p_q.st == ST_ON) && (p_q.cnt == CNT_MAX);
    assign det_status_o = p_q.det_st;
    assign cls_status_o = p_q.cls_st;
    assign ev_cls_o     = p_q.ev_cls;
    assign ev_fault_o   = p_q.ev_fault;
    assign ev_disc_o    = p_q.ev_disc;

    AST_MANUAL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == ST_IDLE && is_manual && !restart_i) |=> (p_q.st == ST_IDLE)); // R3
    AST_GATE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> $past(cls_done_i || pon_i)); // R8
    AST_FAULT_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && fault_i) |=> !gate_en_o); // R10
    AST_KILL_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && osc_kill_i) |=> !gate_en_o); // R12
    AST_POFF_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        poff_i |=> !gate_en_o); // R11
    AST_PGOOD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> !pgood_o); // R9
    AST_CLS_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cls_o |=> !ev_cls_o); // R5

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PGOOD_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_pin_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic                   osc_ok_i,
    input  logic [N_PORTS-1:0]     det_done_i,
    input  logic [3*N_PORTS-1:0]   det_code_i,
    input  logic [N_PORTS-1:0]     cls_done_i,
    input  logic [3*N_PORTS-1:0]   cls_code_i,
    input  logic [N_PORTS-1:0]     fault_i,
    output logic [N_PORTS-1:0]     det_req_o,
    output logic [N_PORTS-1:0]     cls_req_o,
    output logic [N_PORTS-1:0]     gate_en_o,
    output logic [N_PORTS-1:0]     pgood_o,
    output logic [3*N_PORTS-1:0]   det_status_o,
    output logic [3*N_PORTS-1:0]   cls_status_o,
    output logic [N_PORTS-1:0]     ev_cls_done_o,
    output logic [N_PORTS-1:0]     ev_fault_o,
    output logic [N_PORTS-1:0]     ev_disc_o,
    output logic                   osc_fail_o
);

    logic [2*N_PORTS-1:0] mode;
    logic [N_PORTS-1:0]   dc_en, ac_en, restart, pon, poff, osc_kill;
    logic                 soft_rst;

    poe_seq_regs #(
        .N_PORTS (N_PORTS),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_pin_i (auto_pin_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .osc_ok_i   (osc_ok_i),
        .mode_o     (mode),
        .dc_en_o    (dc_en),
        .ac_en_o    (ac_en),
        .osc_fail_o (osc_fail_o),
        .restart_o  (restart),
        .pon_o      (pon),
        .poff_o     (poff),
        .soft_rst_o (soft_rst)
    );

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        assign osc_kill[i] = osc_fail_o && ac_en[i] && !dc_en[i];

        poe_port_fsm #(
            .PGOOD_CYC (PGOOD_CYC)
        ) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .soft_rst_i   (soft_rst),
            .mode_i       (mode[2*i +: 2]),
            .restart_i    (restart[i]),
            .pon_i        (pon[i]),
            .poff_i       (poff[i]),
            .osc_kill_i   (osc_kill[i]),
            .det_done_i   (det_done_i[i]),
            .det_code_i   (det_code_i[3*i +: 3]),
            .cls_done_i   (cls_done_i[i]),
            .cls_code_i   (cls_code_i[3*i +: 3]),
            .fault_i      (fault_i[i]),
            .det_req_o    (det_req_o[i]),
            .cls_req_o    (cls_req_o[i]),
            .gate_en_o    (gate_en_o[i]),
            .pgood_o      (pgood_o[i]),
            .det_status_o (det_status_o[3*i +: 3]),
            .cls_status_o (cls_status_o[3*i +: 3]),
            .ev_cls_o     (ev_cls_done_o[i]),
            .ev_fault_o   (ev_fault_o[i]),
            .ev_disc_o    (ev_disc_o[i])
        );
    end

    AST_RESET_ALL_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (gate_en_o == '0)); // R13

endmodule

// File: tb/sim_poe_port_seq.sv
module sim_poe_port_seq;

    localparam int CLK_PERIOD = 10;
    localparam int PGOOD_CYC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        osc_ok = 1'b1;
    logic [3:0]  det_done = '0;
    logic [11:0] det_code = '0;
    logic [3:0]  cls_done = '0;
    logic [11:0] cls_code = '0;
    logic [3:0]  fault = '0;
    logic [3:0]  det_req, cls_req, gate_en, pgood, ev_cls, ev_fault, ev_disc;
    logic [11:0] det_status, cls_status;
    logic        osc_fail;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poe_port_seq #(.PGOOD_CYC(PGOOD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_pin_i(auto_pin),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .osc_ok_i(osc_ok), .det_done_i(det_done), .det_code_i(det_code),
        .cls_done_i(cls_done), .cls_code_i(cls_code), .fault_i(fault),
        .det_req_o(det_req), .cls_req_o(cls_req), .gate_en_o(gate_en),
        .pgood_o(pgood), .det_status_o(det_status), .cls_status_o(cls_status),
        .ev_cls_done_o(ev_cls), .ev_fault_o(ev_fault), .ev_disc_o(ev_disc),
        .osc_fail_o(osc_fail)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic det(input int p, input logic [2:0] code);
        @(negedge clk);
        det_done[p] = 1'b1; det_code[3*p +: 3] = code;
        @(negedge clk);
        det_done = '0;
    endtask

    task automatic cls(input int p, input logic [2:0] code);
        @(negedge clk);
        cls_done[p] = 1'b1; cls_code[3*p +: 3] = code;
        @(negedge clk);
        cls_done = '0;
    endtask

    task automatic t_reset;
        step(3);
        chk("R1", "gate", 32'(gate_en), 0);
        chk("R1", "pgood", 32'(pgood), 0);
        chk("R1", "det_status", 32'(det_status), 0);
        chk("R1", "cls_status", 32'(cls_status), 0);
        chk("R1", "events", 32'({ev_cls, ev_fault, ev_disc}), 0);
        chk("R1", "osc_fail", 32'(osc_fail), 1);
        chk("R2", "manual default idle", 32'(det_req), 0);
    endtask

    task automatic t_manual_bad;
        wr(8'h18, 8'h01);
        chk("R3", "restart starts port0 only", 32'(det_req), 32'h1);
        det(0, 3'd2);
        chk("R4", "det code low", 32'(det_status[2:0]), 2);
        chk("R4", "back to idle", 32'(det_req), 0);
        chk("R4", "manual bad detect event", 32'(ev_cls), 32'h1);
        step(1);
        chk("R4", "event one cycle", 32'(ev_cls), 0);
        step(3);
        chk("R3", "manual stays idle", 32'(det_req), 0);
    endtask

    task automatic t_manual_ovc;
        wr(8'h18, 8'h01);
        det(0, 3'd3);
        chk("R4", "good goes to class", 32'(cls_req), 32'h1);
        chk("R4", "det code good", 32'(det_status[2:0]), 3);
        wr(8'h19, 8'h01);
        chk("R8", "pon ignored in class", 32'(gate_en), 0);
        chk("R8", "still classifying", 32'(cls_req), 32'h1);
        cls(0, 3'd6);
        chk("R5", "ovc code latched", 32'(cls_status[2:0]), 6);
        chk("R5", "ovc fault event", 32'(ev_fault), 32'h1);
        chk("R5", "ovc no power", 32'(gate_en), 0);
        chk("R5", "ovc no class event", 32'(ev_cls), 0);
        step(1);
        chk("R3", "manual idle after ovc", 32'(det_req | cls_req), 0);
    endtask

    task automatic t_semiauto;
        wr(8'h12, 8'h01);
        step(1);
        chk("R2", "semiauto self detect", 32'(det_req), 32'h1);
        det(0, 3'd3);
        cls(0, 3'd2);
        chk("R5", "class code", 32'(cls_status[2:0]), 2);
        chk("R5", "class event", 32'(ev_cls), 32'h1);
        chk("R6", "waits gate off", 32'(gate_en), 0);
        step(3);
        chk("R6", "still waiting", 32'(gate_en), 0);
        wr(8'h19, 8'h01);
        chk("R6", "pon powers port0", 32'(gate_en), 32'h1);
        chk("R9", "pgood low at power", 32'(pgood), 0);
        step(PGOOD_CYC - 1);
        chk("R9", "pgood low before delay", 32'(pgood), 0);
        step(1);
        chk("R9", "pgood after delay", 32'(pgood), 32'h1);
        @(negedge clk); fault[0] = 1'b1;
        @(negedge clk); fault = '0;
        chk("R10", "fault gate off", 32'(gate_en), 0);
        chk("R10", "fault event", 32'(ev_fault), 32'h1);
        step(1);
        chk("R10", "re-enters detect", 32'(det_req), 32'h1);
    endtask

    task automatic t_auto;
        wr(8'h12, 8'h0C);
        wr(8'h19, 8'h10);
        step(1);
        chk("R7", "auto port1 detects, port0 idle", 32'(det_req), 32'h2);
        det(1, 3'd3);
        cls(1, 3'd2);
        chk("R7", "auto powers itself", 32'(gate_en), 32'h2);
        chk("R14", "port0 unaffected", 32'(det_req[0] | gate_en[0]), 0);
        wr(8'h19, 8'h20);
        chk("R11", "poff gate off", 32'(gate_en), 0);
        step(1);
        chk("R11", "auto re-detects", 32'(det_req), 32'h2);
    endtask

    task automatic t_osc;
        det(1, 3'd3);
        cls(1, 3'd5);
        chk("R7", "class 4 powers", 32'(gate_en), 32'h2);
        wr(8'h13, 8'h20);
        chk("R12", "gate before kill", 32'(gate_en), 32'h2);
        step(1);
        chk("R12", "ac-only port killed", 32'(gate_en), 0);
        chk("R12", "disc event", 32'(ev_disc), 32'h2);
        wr(8'h13, 8'h22);
        det(1, 3'd3);
        cls(1, 3'd1);
        step(2);
        chk("R12", "dc sensing blocks kill", 32'(gate_en), 32'h2);
        wr(8'h1A, 8'h01);
        chk("R12", "flag cleared", 32'(osc_fail), 0);
        wr(8'h13, 8'h20);
        step(1);
        chk("R12", "no kill with osc ok", 32'(gate_en), 32'h2);
        @(negedge clk); osc_ok = 1'b0;
        @(negedge clk);
        chk("R12", "flag on osc loss", 32'(osc_fail), 1);
        chk("R12", "gate one cycle later", 32'(gate_en), 32'h2);
        step(1);
        chk("R12", "killed after loss", 32'(gate_en), 0);
        osc_ok = 1'b1;
    endtask

    task automatic t_reset_all;
        det(1, 3'd3);
        auto_pin = 1'b1;
        wr(8'h1A, 8'h80);
        chk("R13", "gates off", 32'(gate_en), 0);
        chk("R13", "status cleared", 32'({det_status, cls_status}), 0);
        chk("R13", "osc flag set", 32'(osc_fail), 1);
        chk("R13", "no requests", 32'(det_req | cls_req), 0);
        step(1);
        chk("R13", "modes from pin", 32'(det_req), 32'hF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_manual_bad();
        t_manual_ovc();
        t_semiauto();
        t_auto();
        t_osc();
        t_reset_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule